// File: doc/BRIEF.md
# Transmit Short-Frame Padder

This block sits in the byte stream of an Ethernet transmitter, between the buffer that supplies frame bytes and the stage that adds the frame check sequence. Each byte travels on a valid/ready handshake, and a last flag marks the end of a frame. The transmit descriptor supplies a pad-enable flag for each frame, which is presented alongside the frame's first byte. The block forwards every input byte without changing it, in the same order and with the same timing as the input.

When pad-enable is set and a frame ends before it reaches a programmed minimum length, the block keeps the frame open. It stalls the input and appends pad bytes until the frame is exactly the minimum length. The last flag then goes with the final pad byte. The pad value comes from a 16-bit pattern register whose two halves hold the same byte. The block takes the pad enable, the pattern and the minimum length when it accepts the first byte of a frame, so a change in the middle of a frame takes effect only from the next frame.

Top module: `tx_short_frame_padder`

## Requirements
- R1: After reset, with no input offered, `out_valid` is low. While the block is not padding, `in_ready` equals `out_ready`.
- R2: Every input byte appears on `out_data` unchanged and in input order. No byte is lost or repeated under any pattern of `in_valid` gaps or `out_ready` stalls.
- R3: When the frame's pad-enable is 0, a frame of any length L comes out as exactly L bytes, and `out_last` is high with byte L.
- R4: When pad-enable is 1 and L is less than the minimum M, the output frame has exactly M bytes. Bytes L+1 to M equal bits [7:0] of the pad pattern, and `out_last` is high only with byte M.
- R5: When pad-enable is 1 and L is at least M (including M = 0), the frame passes through unchanged as L bytes, with `out_last` on byte L.
- R6: While pad bytes are being sent, `in_ready` stays low and no input byte is accepted.
- R7: The pad pattern is sampled when the first byte of a frame is accepted. A later change to `cfg_pad_pattern` does not alter that frame's pad bytes.
- R8: `in_pad_en` is read only with the first accepted byte of a frame. Its value during later bytes has no effect.
- R9: `cfg_min_len` is sampled when the first byte of a frame is accepted. A later change does not alter that frame's padded length.
- R10: While `out_ready` is low during padding, `out_valid`, `out_data` and `out_last` hold their values.
- R11: The byte count restarts at every frame boundary, so back-to-back frames are each padded on their own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_min_len | input | 16 | Minimum frame length in bytes |
| cfg_pad_pattern | input | 16 | Pad pattern; both bytes hold the same value |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_pad_en | input | 1 | Descriptor pad enable, read with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Output byte is the last of its frame |

## Verification
A byte count that is off by one shows up at the end of the first padded frame: the frame is one byte too long or too short, and `out_last` moves by one position. A count that fails to clear at a frame boundary corrupts the next short frame, which then receives too few pad bytes or none. A frame context latched at the wrong moment shows up in the first frame where the pad enable, pattern or minimum is changed after the first byte, as a wrong pad value or a wrong length. A state machine stuck in padding shows up as `in_ready` staying low, so the next frame never starts.

// File: rtl/tx_pad_pkg.sv
// Package: shared types for the transmit short-frame padder.
// Assumes: included ahead of every padder module in compile order.
package tx_pad_pkg;

    // Two phases of the output stream: forwarding input, or appending pad bytes.
    typedef enum logic [0:0] {
        PH_FORWARD = 1'b0,
        PH_FILL    = 1'b1
    } pad_phase_t;

endpackage

// File: rtl/tx_pad_len_counter.sv
// Module: tx_pad_len_counter
// Counts the bytes already sent in the current output frame. The count
// saturates at its maximum and returns to zero when the frame's last byte
// is handed over.
// Assumes: step and clear are qualified handshakes; clear wins over step.
module tx_pad_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    output logic [LEN_W-1:0] count,
    output logic             at_zero
);

    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    // Advance per output byte, restart at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    // Flag the frame-start position.
    always_comb begin
        at_zero = (count == '0);
    end

    // R11
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R2
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(count));

endmodule

// File: rtl/tx_pad_frame_ctx.sv
// Module: tx_pad_frame_ctx
// Keeps the per-frame settings: pad enable, pad byte and minimum length.
// They are captured together with the first accepted byte of a frame. While
// that first byte is on offer, the live inputs are passed through, so the
// decision for a one-byte frame uses the values shown with it.
// Assumes: capture is high only on the first-byte handshake; the pattern
// has equal halves.
module tx_pad_frame_ctx #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    localparam int PAT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              capture,
    input  logic              live_pad_en,
    input  logic [LEN_W-1:0]  live_min_len,
    input  logic [PAT_W-1:0]  live_pattern,
    output logic              eff_pad_en,
    output logic [LEN_W-1:0]  eff_min_len,
    output logic [DATA_W-1:0] pad_byte
);

    logic              pad_en_q;
    logic [LEN_W-1:0]  min_len_q;
    logic [DATA_W-1:0] pad_byte_q;

    // Latch the frame's settings on its first accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_en_q   <= 1'b0;
            min_len_q  <= '0;
            pad_byte_q <= '0;
        end else if (capture) begin
            pad_en_q   <= live_pad_en;
            min_len_q  <= live_min_len;
            pad_byte_q <= live_pattern[DATA_W-1:0];
        end
    end

    // Choose live values at frame start, latched values afterwards.
    always_comb begin
        eff_pad_en  = first ? live_pad_en  : pad_en_q;
        eff_min_len = first ? live_min_len : min_len_q;
        pad_byte    = pad_byte_q;
    end

    // R7
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(pad_byte_q) && $stable(min_len_q) && $stable(pad_en_q)));

    // R4
    pattern_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (live_pattern[PAT_W-1:DATA_W] == live_pattern[DATA_W-1:0]));

endmodule

// File: rtl/tx_pad_phase_fsm.sv
// Module: tx_pad_phase_fsm
// Two-state sequencer. It enters the fill phase when a short frame's last
// input byte is accepted, and returns to forwarding when the final pad byte
// is handed over.
// Assumes: enter_fill occurs only while forwarding, fill_done only while filling.
module tx_pad_phase_fsm
    import tx_pad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_fill,
    input  logic       fill_done,
    output pad_phase_t phase
);

    pad_phase_t phase_nx;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_FORWARD: if (enter_fill) phase_nx = PH_FILL;
            PH_FILL:    if (fill_done)  phase_nx = PH_FORWARD;
            default:    phase_nx = PH_FORWARD;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FORWARD;
        end else begin
            phase <= phase_nx;
        end
    end

    // R4
    fill_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FILL) && !fill_done) |=> (phase == PH_FILL));

    // R11
    fill_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FILL) && fill_done) |=> (phase == PH_FORWARD));

endmodule

// File: rtl/tx_short_frame_padder.sv
// Module: tx_short_frame_padder (top)
// Forwards a transmit byte stream unchanged. When a frame's pad enable is
// set and the frame ends short of the programmed minimum, it stalls the
// input and appends pad bytes until the frame reaches exactly the minimum
// length, then marks the end of the frame on the last pad byte.
// Assumes: the upstream source holds its byte stable while in_ready is low;
// the pad pattern has equal halves.
module tx_short_frame_padder
    import tx_pad_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    localparam int PAT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_min_len,
    input  logic [PAT_W-1:0]  cfg_pad_pattern,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_pad_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);

    pad_phase_t        phase;
    logic [LEN_W-1:0]  sent_cnt;
    logic              cnt_zero;
    logic              frame_first;
    logic              eff_pad_en;
    logic [LEN_W-1:0]  eff_min_len;
    logic [DATA_W-1:0] pad_byte;
    logic [LEN_W:0]    len_after;
    logic              short_frame;
    logic              fill_final;
    logic              in_hs;
    logic              out_hs;
    logic              enter_fill;
    logic              fill_done;
    logic              frame_end;

    // Length reached once the current output byte is taken.
    always_comb begin
        len_after   = {1'b0, sent_cnt} + 1'b1;
        frame_first = (phase == PH_FORWARD) && cnt_zero;
        short_frame = eff_pad_en && (len_after < {1'b0, eff_min_len});
        fill_final  = (len_after >= {1'b0, eff_min_len});
    end

    // Output steering between forwarded and pad bytes.
    always_comb begin
        if (phase == PH_FILL) begin
            out_valid = 1'b1;
            out_data  = pad_byte;
            out_last  = fill_final;
            in_ready  = 1'b0;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = in_last && !short_frame;
            in_ready  = out_ready;
        end
    end

    // Handshake and frame-event decode.
    always_comb begin
        in_hs      = in_valid && in_ready;
        out_hs     = out_valid && out_ready;
        enter_fill = in_hs && in_last && short_frame;
        fill_done  = (phase == PH_FILL) && out_hs && fill_final;
        frame_end  = out_hs && out_last;
    end

    tx_pad_len_counter #(
        .LEN_W (LEN_W)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (out_hs),
        .clear   (frame_end),
        .count   (sent_cnt),
        .at_zero (cnt_zero)
    );

    tx_pad_frame_ctx #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .first        (frame_first),
        .capture      (frame_first && in_hs),
        .live_pad_en  (in_pad_en),
        .live_min_len (cfg_min_len),
        .live_pattern (cfg_pad_pattern),
        .eff_pad_en   (eff_pad_en),
        .eff_min_len  (eff_min_len),
        .pad_byte     (pad_byte)
    );

    tx_pad_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_fill (enter_fill),
        .fill_done  (fill_done),
        .phase      (phase)
    );

    // R6
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL) |-> !in_ready);

    // R10
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FILL) && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    // R4
    fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (len_after == {1'b0, eff_min_len}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FORWARD) && !in_valid) |-> !out_valid);

endmodule

// File: tb/tx_short_frame_padder_test.sv
// Bench: sweeps frame length, minimum length and pad enable under
// pseudo-random input gaps and output stalls, and computes each expected
// frame arithmetically.
module tx_short_frame_padder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_min_len;
    logic [15:0] cfg_pad_pattern;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_data;
    logic        in_last;
    logic        in_pad_en;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_last;

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] lfsr   = 16'hACE1;

    always #10 clk = ~clk;

    tx_short_frame_padder uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_min_len     (cfg_min_len),
        .cfg_pad_pattern (cfg_pad_pattern),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_data         (in_data),
        .in_last         (in_last),
        .in_pad_en       (in_pad_en),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_data        (out_data),
        .out_last        (out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input int base, input int i);
        return 8'((base + i * 37 + 5) & 255);
    endfunction

    // One frame: L input bytes, pad enable pe, minimum minl, pad byte pat.
    // After the first byte is taken, pad enable, minimum and pattern are
    // changed to check that they are sampled at frame start (R7, R8, R9).
    task automatic run_frame(input int L, input bit pe, input int minl,
                             input logic [7:0] pat, input int base);
        int    exp_len  = (pe && (L < minl)) ? minl : L;
        int    idx      = 0;
        int    oidx     = 0;
        int    cyc      = 0;
        int    byte_err = 0;
        int    bad_rdy  = 0;
        int    last_pos = -1;
        int    last_cnt = 0;
        bit    done     = 1'b0;
        string tag      = pe ? ((L < minl) ? "R4" : "R5") : "R3";
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[1];
            if (idx < L) begin
                in_valid = !(lfsr[2] & lfsr[3] & lfsr[4]);
                in_data  = frame_byte(base, idx);
                in_last  = (idx == L - 1);
            end else begin
                in_valid = (exp_len > L);
                in_data  = 8'hEE;
                in_last  = 1'b1;
            end
            in_pad_en       = (idx == 0) ? pe : !pe;
            cfg_min_len     = (idx == 0) ? 16'(minl) : 16'(minl + 5);
            cfg_pad_pattern = (idx == 0) ? {pat, pat} : {~pat, ~pat};
            #1;
            if (idx >= L && in_ready) bad_rdy++;
            if (idx < L && in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                if (out_data != ((oidx < L) ? frame_byte(base, oidx) : pat)) byte_err++;
                if (out_last) begin
                    last_cnt++;
                    last_pos = oidx;
                    done = 1'b1;
                end
                oidx++;
            end
        end
        check(done, {tag, " R11 frame completes"}, int'(done), 1);
        check(oidx == exp_len, {tag, " R8 R9 output length"}, oidx, exp_len);
        check(last_pos == exp_len - 1, {tag, " end marker position"}, last_pos, exp_len - 1);
        check(byte_err == 0, "R2 R7 R10 byte content", byte_err, 0);
        check(bad_rdy == 0, "R6 input stalled while padding", bad_rdy, 0);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n           = 1'b0;
        in_valid        = 1'b0;
        in_data         = '0;
        in_last         = 1'b0;
        in_pad_en       = 1'b0;
        out_ready       = 1'b1;
        cfg_min_len     = 16'd64;
        cfg_pad_pattern = 16'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready follows out_ready high", int'(in_ready), 1);
        out_ready = 1'b0;
        #1;
        check(in_ready == 1'b0, "R1 in_ready follows out_ready low", int'(in_ready), 0);

        // Sweep of small minimums, lengths and both pad enables (R11: back to back).
        for (int m = 0; m < 10; m++) begin
            for (int l = 1; l <= 10; l++) begin
                for (int p = 0; p < 2; p++) begin
                    run_frame(l, p[0], m, 8'(8'h30 + m * 11 + l), m * 16 + l * 3 + p);
                end
            end
        end

        // Typical minimum of 64 bytes around the boundary.
        run_frame(1,  1'b1, 64, 8'h00, 7);
        run_frame(63, 1'b1, 64, 8'hA5, 9);
        run_frame(64, 1'b1, 64, 8'hC3, 11);
        run_frame(65, 1'b1, 64, 8'h3C, 13);
        run_frame(20, 1'b0, 64, 8'h77, 15);

        @(negedge clk);
        in_valid = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule